// File: doc/BRIEF.md
# Little-Endian Load Aligner with Extension

This block is the read half of a load unit. It takes a request for a 1, 2 or 4 byte value at any byte address, whether aligned or not, and reads the bytes one per cycle from a synchronous byte-wide memory. It places the bytes in little-endian order and widens the value to 32 bits by filling the upper bits with zeros or with copies of the value's top bit, as the request selects. The result comes back on a single-cycle done strobe, together with a flag that tells whether the access was naturally aligned. A performance counter can use that flag.

The request side is a valid/ready interface. `req_ready` is high only while the block is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a load is in flight `req_ready` stays low, so a requester holds its request or withdraws it, and nothing it presents in that time is taken. `req_ready` goes high again in the same cycle as the done strobe, so loads can follow one another without a gap cycle. The memory returns the byte for an address in the cycle after that address was presented with `mem_rd_en` high.

Top module: `le_load_unit`

## Requirements
- R1: The byte read from address A+k is placed in result bits [8k+7:8k], so the lowest address gives the least significant byte.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and 3 is never presented. An accepted request makes exactly that many memory reads, one per cycle at consecutive addresses starting at `req_addr`, and the address wraps modulo 2^ADDR_W.
- R3: When `req_sext` is 0, every result bit above the loaded value is 0.
- R4: When `req_sext` is 1, every result bit above the loaded value equals the loaded value's most significant bit.
- R5: A 4-byte load returns the assembled word unchanged whatever `req_sext` is.
- R6: Unaligned addresses are legal and return the same bytes, in the same order, as any other access.
- R7: `rsp_aligned` is 1 exactly when the request address is a multiple of its size in bytes. A 1-byte access is always aligned.
- R8: `rsp_valid` is high for exactly one cycle per request. It rises N+1 rising edges after the accepting edge, where N is the byte count, and `rsp_data` and `rsp_aligned` are valid in that cycle.
- R9: `req_ready` is low from the cycle after acceptance until the `rsp_valid` cycle, when it is high again. A request presented and withdrawn while the block is busy starts no memory reads and produces no response.
- R10: While reset is asserted and after it is released, `req_ready` is 1 and `rsp_valid` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the lowest byte |
| req_size | input | 2 | Byte count: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_sext | input | 1 | 1 = sign fill, 0 = zero fill |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after the read strobe |
| rsp_valid | output | 1 | Single-cycle done strobe |
| rsp_data | output | 32 | Extended little-endian result |
| rsp_aligned | output | 1 | Access was naturally aligned |

## Verification
The assertions assume that `req_size` is never 3 while `req_valid` is high. They also assume that the memory answers every read on the very next cycle, since the capture logic does not wait for the data. The bench sends only the three legal sizes, and its memory model registers each read so that the byte is ready one cycle later, as the block expects. The assertions on consecutive read addresses and on the ready hand-off hold only under these conditions. The bench also withdraws the request it presents while the block is busy before `req_ready` rises, so that request is never accepted and cannot be mistaken for a new load.

// File: rtl/le_load_pkg.sv
package le_load_pkg;

  // Request size, encoded as log2 of the byte count
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  // Index of the last byte lane a request of size s touches
  function automatic logic [1:0] last_lane(ld_size_e s);
    case (s)
      SZ_BYTE: last_lane = 2'd0;
      SZ_HALF: last_lane = 2'd1;
      default: last_lane = 2'd3;
    endcase
  endfunction

  // Natural alignment from the two low address bits
  function automatic logic is_aligned(logic [1:0] lo, ld_size_e s);
    case (s)
      SZ_BYTE: is_aligned = 1'b1;
      SZ_HALF: is_aligned = ~lo[0];
      default: is_aligned = (lo == 2'b00);
    endcase
  endfunction

endpackage

// File: rtl/ld_seq.sv
module ld_seq
  import le_load_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  ld_size_e          req_size,
  input  logic              req_sext,
  output logic              req_ready,
  output logic              start,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              cap_valid,
  output logic [IDX_W-1:0]  cap_lane,
  output logic              fire,
  output ld_size_e          cur_size,
  output logic              cur_sext,
  output logic              cur_aligned
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic              cap_valid_q;
  logic [IDX_W-1:0]  cap_lane_q;

  assign req_ready   = (state_q == ST_IDLE);
  assign start       = req_valid && req_ready;
  assign mem_rd_en   = (state_q == ST_FETCH);
  assign mem_rd_addr = base_q + ADDR_W'(idx_q);
  assign fire        = (state_q == ST_DRAIN);
  assign last_idx    = IDX_W'(last_lane(cur_size));
  assign cap_valid   = cap_valid_q;
  assign cap_lane    = cap_lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      idx_q       <= '0;
      cur_size    <= SZ_BYTE;
      cur_sext    <= 1'b0;
      cur_aligned <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            base_q      <= req_addr;
            cur_size    <= req_size;
            cur_sext    <= req_sext;
            cur_aligned <= is_aligned(req_addr[1:0], req_size);
            idx_q       <= '0;
            state_q     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (idx_q == last_idx) state_q <= ST_DRAIN;
          else                   idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // The byte for each issued read arrives one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid_q <= 1'b0;
      cap_lane_q  <= '0;
    end else begin
      cap_valid_q <= mem_rd_en;
      cap_lane_q  <= idx_q;
    end
  end

  // R2: only the three legal sizes are ever requested
  assert_legal_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != SZ_BAD));

  // R2: back-to-back reads walk up one byte address at a time
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

  // R9: an accepted request makes the block busy on the next cycle
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/ld_collect.sv
module ld_collect #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    cap_valid,
  input  logic [IDX_W-1:0]        cap_lane,
  input  logic [BYTE_W-1:0]       cap_byte,
  output logic [LANES*BYTE_W-1:0] word_out
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              hit;

    assign hit = cap_valid && (cap_lane == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (clear) lane_q <= '0;
      else if (hit)   lane_q <= cap_byte;
    end

    // The byte arriving this cycle bypasses the lane register
    assign word_out[k*BYTE_W +: BYTE_W] = hit ? cap_byte : lane_q;
  end

endmodule

// File: rtl/ld_extend.sv
module ld_extend
  import le_load_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] word_in,
  input  ld_size_e          size,
  input  logic              sext,
  output logic [DATA_W-1:0] data_out
);

  int   nbits;
  logic msb;
  logic fill;

  always_comb begin
    case (size)
      SZ_BYTE: begin nbits = BYTE_W;     msb = word_in[BYTE_W-1];   end
      SZ_HALF: begin nbits = 2 * BYTE_W; msb = word_in[2*BYTE_W-1]; end
      default: begin nbits = DATA_W;     msb = word_in[DATA_W-1];   end
    endcase
    fill = sext & msb;
    for (int i = 0; i < DATA_W; i++) begin
      data_out[i] = (i < nbits) ? word_in[i] : fill;
    end
  end

endmodule

// File: rtl/le_load_unit.sv
module le_load_unit
  import le_load_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_sext,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_aligned
);

  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic              start;
  logic              cap_valid;
  logic [IDX_W-1:0]  cap_lane;
  logic              fire;
  ld_size_e          cur_size;
  logic              cur_sext;
  logic              cur_aligned;
  logic [DATA_W-1:0] assembled;
  logic [DATA_W-1:0] extended;

  ld_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (ld_size_e'(req_size)),
    .req_sext   (req_sext),
    .req_ready  (req_ready),
    .start      (start),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .cap_valid  (cap_valid),
    .cap_lane   (cap_lane),
    .fire       (fire),
    .cur_size   (cur_size),
    .cur_sext   (cur_sext),
    .cur_aligned(cur_aligned)
  );

  ld_collect #(.LANES(LANES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .cap_valid(cap_valid),
    .cap_lane (cap_lane),
    .cap_byte (mem_rd_data),
    .word_out (assembled)
  );

  ld_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_extend (
    .word_in (assembled),
    .size    (cur_size),
    .sext    (cur_sext),
    .data_out(extended)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_aligned <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_data    <= extended;
        rsp_aligned <= cur_aligned;
      end
    end
  end

  // R8: the done strobe never lasts two cycles
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: the block is free again in the cycle it reports
  assert_ready_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R3: a zero-filled byte load leaves the upper bits clear
  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cur_sext && cur_size == SZ_BYTE) |-> (rsp_data[DATA_W-1:BYTE_W] == '0));

  // R4: a sign-filled 2-byte load copies bit 15 upward
  assert_sign_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cur_sext && cur_size == SZ_HALF) |->
      (rsp_data[DATA_W-1:2*BYTE_W] == {(DATA_W-2*BYTE_W){rsp_data[2*BYTE_W-1]}}));

  // R10: no memory read without a request in flight
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !$past(start)) |-> !mem_rd_en);

endmodule

// File: tb/tb_le_load_unit.sv
module tb_le_load_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_sext = 1'b0;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_aligned;

  always #5 clk = ~clk;

  le_load_unit #(.ADDR_W(24), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_sext(req_sext),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_aligned(rsp_aligned)
  );

  // Synchronous byte memory: the byte is ready one cycle after the read
  logic [7:0] mem [256];
  logic [7:0] mem_q;
  always_ff @(posedge clk) if (mem_rd_en) mem_q <= mem[mem_rd_addr[7:0]];
  assign mem_rd_data = mem_q;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // Read monitor
  int          rd_cnt = 0;
  logic [23:0] rd_first = '0;
  bit          rd_seq_ok = 1'b1;
  always @(negedge clk) begin
    if (mem_rd_en) begin
      if (rd_cnt == 0) rd_first = mem_rd_addr;
      else if (mem_rd_addr != 24'(rd_first + 24'(rd_cnt))) rd_seq_ok = 1'b0;
      rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] addr;
    logic [1:0]  size;
    logic        sext;
    logic [31:0] data;
    logic        al;
  } vec_t;

  // Memory image: 0x00..0x0F below, 0x20:00 FF, 0x30:00 81, 0xFE:AA, 0xFF:BB
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{24'h528000, 2'd2, 1'b0, 32'hA3318850, 1'b1},  // R1 aligned word
    '{24'h528002, 2'd2, 1'b0, 32'hFFB2A331, 1'b0},  // R6 unaligned word
    '{24'h528005, 2'd2, 1'b1, 32'h077D0FFF, 1'b0},  // R5 word ignores sign fill
    '{24'h000020, 2'd1, 1'b0, 32'h0000FF00, 1'b1},  // R3
    '{24'h000020, 2'd1, 1'b1, 32'hFFFFFF00, 1'b1},  // R4
    '{24'h000030, 2'd1, 1'b1, 32'hFFFF8100, 1'b1},  // R4
    '{24'h000030, 2'd1, 1'b0, 32'h00008100, 1'b1},  // R3
    '{24'h000031, 2'd0, 1'b1, 32'hFFFFFF81, 1'b1},  // R4 byte
    '{24'h000031, 2'd0, 1'b0, 32'h00000081, 1'b1},  // R3 byte
    '{24'h528003, 2'd1, 1'b1, 32'hFFFFB2A3, 1'b0},  // R6 unaligned half
    '{24'h528004, 2'd2, 1'b1, 32'h7D0FFFB2, 1'b1},  // R5 positive word
    '{24'hFFFFFE, 2'd2, 1'b0, 32'h8850BBAA, 1'b0},  // R2 address wrap
    '{24'h000020, 2'd0, 1'b1, 32'h00000000, 1'b1},  // R4 zero byte stays zero
    '{24'h528001, 2'd1, 1'b0, 32'h00003188, 1'b0}   // R7 odd half unaligned
  };

  task automatic run_vec(input vec_t v);
    int edges = 0;
    int nb = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
    string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0; rd_seq_ok = 1'b1;
    req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_sext = v.sext;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low while busy", 32'(req_ready), 32'd0);
    do begin
      @(posedge clk); edges++;
      @(negedge clk);
    end while (!rsp_valid && edges < 20);
    tag = (v.size == 2'd2) ? (v.al ? "R5" : "R6") : (v.sext ? "R4" : "R3");
    chk(rsp_data == v.data, $sformatf("R1 %s data @%h", tag, v.addr), rsp_data, v.data);
    chk(rsp_aligned == v.al, $sformatf("R7 aligned @%h", v.addr), 32'(rsp_aligned), 32'(v.al));
    chk(edges == nb + 1, "R8 latency", 32'(edges), 32'(nb + 1));
    chk(rd_cnt == nb && rd_first == v.addr && rd_seq_ok,
        $sformatf("R2 read count/addr @%h", v.addr), 32'(rd_cnt), 32'(nb));
    chk(req_ready, "R9 ready with done", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R8 strobe one cycle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h00] = 8'h50; mem[8'h01] = 8'h88; mem[8'h02] = 8'h31; mem[8'h03] = 8'hA3;
    mem[8'h04] = 8'hB2; mem[8'h05] = 8'hFF; mem[8'h06] = 8'h0F; mem[8'h07] = 8'h7D;
    mem[8'h08] = 8'h07; mem[8'h09] = 8'hD0; mem[8'h0A] = 8'hBE; mem[8'h0B] = 8'h22;
    mem[8'h0C] = 8'h11; mem[8'h0D] = 8'h96; mem[8'h0E] = 8'h00; mem[8'h0F] = 8'h14;
    mem[8'h20] = 8'h00; mem[8'h21] = 8'hFF;
    mem[8'h30] = 8'h00; mem[8'h31] = 8'h81;
    mem[8'hFE] = 8'hAA; mem[8'hFF] = 8'hBB;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R10 no strobe in reset", 32'(rsp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R10 no read in reset", 32'(mem_rd_en), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R10 idle after reset",
        {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'h4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: a request shown and withdrawn while busy is not taken
    begin
      int edges = 0;
      int spurious = 0;
      @(negedge clk);
      rd_cnt = 0; rd_seq_ok = 1'b1;
      req_valid = 1'b1; req_addr = 24'h528000; req_size = 2'd2; req_sext = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_addr = 24'h000020; req_size = 2'd1; req_sext = 1'b1;
      chk(!req_ready, "R9 busy request held off", 32'(req_ready), 32'd0);
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && edges < 20) begin @(negedge clk); edges++; end
      chk(rsp_data == 32'hA3318850, "R9 original load returned", rsp_data, 32'hA3318850);
      chk(rd_cnt == 4, "R9 only original reads", 32'(rd_cnt), 32'd4);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (rsp_valid) spurious++;
      end
      chk(spurious == 0, "R9 no response for withdrawn request", 32'(spurious), 32'd0);
      chk(rd_cnt == 4, "R9 no reads for withdrawn request", 32'(rd_cnt), 32'd4);
    end

    // R8: back-to-back requests, the second taken in the done cycle
    begin
      int edges = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h000031; req_size = 2'd0; req_sext = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_addr = 24'h000030; req_size = 2'd1; req_sext = 1'b1;
      while (!req_ready && edges < 20) begin @(negedge clk); edges++; end
      chk(rsp_valid && rsp_data == 32'h00000081, "R8 first of pair", rsp_data, 32'h00000081);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      edges = 0;
      while (!rsp_valid && edges < 20) begin @(negedge clk); edges++; end
      chk(rsp_data == 32'hFFFF8100, "R4 second of pair", rsp_data, 32'hFFFF8100);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule